// File: doc/BRIEF.md
# Disk Sector Serial Stream Formatter

This block turns a run of disk sectors into one serial bit stream, one bit per step. A step is a cycle with the bit clock enable high, or, with the diagnostic select high, each rising edge of a maintenance clock input that software can toggle by hand. Every sector has the same layout: a zero preamble ending in a single sync one, 256 data words shifted out MSB first, a 32-bit CRC over those data bits, a 16-bit postamble of zeros and a trailing zero gap. A word-width mode picks 16-bit or 18-bit words. Data words come in over a ready/valid interface.

A start pulse loads a sector count and latches the word-width mode. The block then sends sectors back to back, counting the count down after each one. When the final gap bit has gone out it drops busy and pulses done. If no word is waiting when one is needed, zeros are sent in its place and a sticky underflow flag is set.

Top module: `sector_stream_fmt`

## Requirements
- R1: After reset, ready_o, bit_o, bit_stb_o, busy_o, done_o and underflow_o are all low.
- R2: Each sector begins with 255 zero bits followed by one bit of value 1.
- R3: Next come 256 data words, MSB first. With mode 0 each word is data_i[15:0] and data_i[17:16] have no effect. With mode 1 each word is all 18 bits of data_i.
- R4: Right after the data come 32 CRC bits, MSB first. The CRC is computed over the sector's serialized data bits, with generator 0x04C11DB7, a zero seed, no reflection and no final inversion.
- R5: After the CRC come 16 zero postamble bits, then 112 zero gap bits in mode 0 or 96 in mode 1. A sector is therefore 4512 bits in mode 0 and 5008 bits in mode 1.
- R6: Sectors follow each other with no pause until the loaded count is used up. In the cycle whose bit_stb_o carries the final gap bit, busy_o is already low. done_o is high for exactly one cycle, the cycle after that one.
- R7: A start_i pulse while busy_o is high has no effect. A start_i pulse with sec_cnt_i equal to zero has no effect.
- R8: mode18_i is sampled only when a start is accepted. Changing it during a transfer does not alter the stream.
- R9: ready_o is high only while busy, with no word held and with words still owed for the transfer. A word whose handshake falls in the same step that needs it is sent at once.
- R10: If no word is available at the step that needs one, that word slot goes out as zeros and is not fetched later. underflow_o is then set and stays set until the next accepted start.
- R11: With diag_i high, each rising edge of mclk_i gives exactly one step and bit_en_i is ignored. With diag_i low, each cycle with bit_en_i high is a step.
- R12: bit_stb_o is high for one cycle after each step, with the new bit on bit_o. bit_o holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| sec_cnt_i | input | SEC_W | Number of sectors, loaded at start |
| mode18_i | input | 1 | Word width: 0 = 16-bit, 1 = 18-bit |
| diag_i | input | 1 | Select maintenance clock stepping |
| mclk_i | input | 1 | Maintenance clock, one step per rising edge |
| bit_en_i | input | 1 | Free-running bit clock enable |
| data_i | input | 18 | Data word |
| valid_i | input | 1 | Data word valid |
| ready_o | output | 1 | Data word requested |
| bit_o | output | 1 | Serial bit |
| bit_stb_o | output | 1 | New bit strobe |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| underflow_o | output | 1 | Sticky data underflow flag |

## Verification
Two things can land in the same cycle: the handshake that fills the empty word holder, and the step that takes the first bit of that same word. The bench provokes this in diagnostic mode. It holds valid low through the preamble with ready high, then raises valid in the very cycle it raises the maintenance clock for the first data bit. The coincidence is judged correct if the stream matches the model word for word and underflow stays low. The opposite case, where valid stays low past that step, must give a zero word, a set underflow flag and every later word shifted by one slot.

// File: rtl/ssf_pkg.sv
package ssf_pkg;
  localparam int unsigned W16 = 16;
  localparam int unsigned W18 = 18;
  localparam int unsigned CRC_W = 32;
  localparam int unsigned POST_BITS = 16;

  typedef enum logic [2:0] {
    F_IDLE,
    F_PRE,
    F_DATA,
    F_CRC,
    F_POST,
    F_GAP
  } field_e;
endpackage

// File: rtl/ssf_seq.sv
module ssf_seq
  import ssf_pkg::*;
#(
  parameter int unsigned SEC_W    = 8,
  parameter int unsigned WORDS    = 256,
  parameter int unsigned PRE_BITS = 256,
  parameter int unsigned GAP16    = 112,
  parameter int unsigned GAP18    = 96,
  localparam int unsigned CNT_W   = $clog2(WORDS * W18 + PRE_BITS + 1),
  localparam int unsigned WB_W    = $clog2(W18)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SEC_W-1:0] sec_cnt_i,
  input  logic             mode18_i,
  input  logic             step_i,
  output logic             start_acc_o,
  output logic             busy_o,
  output logic             mode18_o,
  output field_e           field_o,
  output logic             slot_o,
  output logic             pre_last_o,
  output logic             last_o
);
  field_e           field_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WB_W-1:0]  wbit_q;
  logic [SEC_W-1:0] sec_q;
  logic             busy_q, mode_q;
  logic [WB_W-1:0]  wlast;

  assign wlast       = mode_q ? WB_W'(W18 - 1) : WB_W'(W16 - 1);
  assign start_acc_o = start_i && !busy_q && (sec_cnt_i != '0);
  assign busy_o      = busy_q;
  assign mode18_o    = mode_q;
  assign field_o     = field_q;
  assign slot_o      = (field_q == F_DATA) && (wbit_q == '0);
  assign pre_last_o  = (field_q == F_PRE) && (cnt_q == '0);
  assign last_o      = busy_q && step_i && (field_q == F_GAP) && (cnt_q == '0)
                       && (sec_q == SEC_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      field_q <= F_IDLE;
      cnt_q   <= '0;
      wbit_q  <= '0;
      sec_q   <= '0;
      busy_q  <= 1'b0;
      mode_q  <= 1'b0;
    end else if (start_acc_o) begin
      busy_q  <= 1'b1;
      field_q <= F_PRE;
      cnt_q   <= CNT_W'(PRE_BITS - 1);
      wbit_q  <= '0;
      sec_q   <= sec_cnt_i;
      mode_q  <= mode18_i;
    end else if (busy_q && step_i) begin
      if (cnt_q == '0) begin
        wbit_q <= '0;
        unique case (field_q)
          F_PRE: begin
            field_q <= F_DATA;
            cnt_q   <= mode_q ? CNT_W'(WORDS * W18 - 1) : CNT_W'(WORDS * W16 - 1);
          end
          F_DATA: begin
            field_q <= F_CRC;
            cnt_q   <= CNT_W'(CRC_W - 1);
          end
          F_CRC: begin
            field_q <= F_POST;
            cnt_q   <= CNT_W'(POST_BITS - 1);
          end
          F_POST: begin
            field_q <= F_GAP;
            cnt_q   <= mode_q ? CNT_W'(GAP18 - 1) : CNT_W'(GAP16 - 1);
          end
          default: begin
            if (sec_q == SEC_W'(1)) begin
              busy_q  <= 1'b0;
              field_q <= F_IDLE;
            end else begin
              field_q <= F_PRE;
              cnt_q   <= CNT_W'(PRE_BITS - 1);
            end
            sec_q <= sec_q - SEC_W'(1);
          end
        endcase
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (field_q == F_DATA) wbit_q <= (wbit_q == wlast) ? '0 : wbit_q + WB_W'(1);
      end
    end
  end

  assert_mode_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> $stable(mode_q));

  assert_start_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && !step_i) |=> ($stable(sec_q) && busy_q));
endmodule

// File: rtl/ssf_crc.sv
module ssf_crc #(
  parameter logic [31:0] POLY = 32'h04C1_1DB7,
  parameter logic [31:0] SEED = 32'h0000_0000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic upd_i,
  input  logic din_i,
  input  logic shift_i,
  output logic msb_o
);
  logic [31:0] crc_q;

  assign msb_o = crc_q[31];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= SEED;
    else if (clear_i) crc_q <= SEED;
    else if (upd_i)   crc_q <= {crc_q[30:0], 1'b0} ^ ((crc_q[31] ^ din_i) ? POLY : 32'h0);
    else if (shift_i) crc_q <= {crc_q[30:0], 1'b0};
  end
endmodule

// File: rtl/ssf_word_feed.sv
module ssf_word_feed
  import ssf_pkg::*;
#(
  parameter int unsigned SEC_W = 8,
  parameter int unsigned WORDS = 256,
  localparam int unsigned WL_W = SEC_W + $clog2(WORDS) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_acc_i,
  input  logic [SEC_W-1:0] sec_cnt_i,
  input  logic             busy_i,
  input  logic             mode18_i,
  input  logic             slot_i,
  input  logic             adv_i,
  input  logic             last_i,
  input  logic [W18-1:0]   data_i,
  input  logic             valid_i,
  output logic             ready_o,
  output logic             bit_o,
  output logic             underflow_o
);
  logic [W18-1:0] hold_q, sh_q, in_w, new_w, cur_w;
  logic           full_q, uf_q, hs;
  logic [WL_W-1:0] wl_q;

  assign ready_o     = busy_i && !full_q && (wl_q != '0);
  assign hs          = valid_i && ready_o;
  assign in_w        = mode18_i ? data_i : {2'b00, data_i[W16-1:0]};
  // bypass: a word handed over in its own slot goes straight out
  assign new_w       = full_q ? hold_q : (hs ? in_w : '0);
  assign cur_w       = slot_i ? new_w : sh_q;
  assign bit_o       = mode18_i ? cur_w[W18-1] : cur_w[W16-1];
  assign underflow_o = uf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      sh_q   <= '0;
      full_q <= 1'b0;
      uf_q   <= 1'b0;
      wl_q   <= '0;
    end else if (start_acc_i) begin
      full_q <= 1'b0;
      uf_q   <= 1'b0;
      wl_q   <= WL_W'(sec_cnt_i) * WL_W'(WORDS);
    end else begin
      if (slot_i) begin
        sh_q <= new_w << 1;
        if (full_q) begin
          full_q <= 1'b0;
        end else if (!hs) begin
          uf_q <= 1'b1;
          wl_q <= wl_q - WL_W'(1);
        end
      end else begin
        if (adv_i) sh_q <= sh_q << 1;
        if (hs) begin
          hold_q <= in_w;
          full_q <= 1'b1;
        end
      end
      if (hs) wl_q <= wl_q - WL_W'(1);
    end
  end

  assert_drained_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_i |-> (wl_q == '0) && !full_q);

  assert_uf_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf_q && !start_acc_i) |=> uf_q);
endmodule

// File: rtl/sector_stream_fmt.sv
module sector_stream_fmt
  import ssf_pkg::*;
#(
  parameter int unsigned SEC_W    = 8,
  parameter int unsigned WORDS    = 256,
  parameter int unsigned PRE_BITS = 256,
  parameter int unsigned GAP16    = 112,
  parameter int unsigned GAP18    = 96,
  parameter logic [31:0] CRC_POLY = 32'h04C1_1DB7,
  parameter logic [31:0] CRC_SEED = 32'h0000_0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SEC_W-1:0] sec_cnt_i,
  input  logic             mode18_i,
  input  logic             diag_i,
  input  logic             mclk_i,
  input  logic             bit_en_i,
  input  logic [17:0]      data_i,
  input  logic             valid_i,
  output logic             ready_o,
  output logic             bit_o,
  output logic             bit_stb_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             underflow_o
);
  field_e field;
  logic   start_acc, busy, mode18, slot, pre_last, last;
  logic   step, mclk_q, data_bit, crc_bit, nxt_bit;
  logic   bit_q, stb_q, done_pend_q, done_q;

  assign step = busy && (diag_i ? (mclk_i && !mclk_q) : bit_en_i);

  ssf_seq #(
    .SEC_W(SEC_W), .WORDS(WORDS), .PRE_BITS(PRE_BITS), .GAP16(GAP16), .GAP18(GAP18)
  ) seq_i (
    .clk_i, .rst_ni, .start_i, .sec_cnt_i, .mode18_i,
    .step_i(step), .start_acc_o(start_acc), .busy_o(busy), .mode18_o(mode18),
    .field_o(field), .slot_o(slot), .pre_last_o(pre_last), .last_o(last)
  );

  ssf_word_feed #(.SEC_W(SEC_W), .WORDS(WORDS)) feed_i (
    .clk_i, .rst_ni, .start_acc_i(start_acc), .sec_cnt_i, .busy_i(busy),
    .mode18_i(mode18), .slot_i(step && slot),
    .adv_i(step && (field == F_DATA) && !slot), .last_i(last),
    .data_i, .valid_i, .ready_o, .bit_o(data_bit), .underflow_o
  );

  ssf_crc #(.POLY(CRC_POLY), .SEED(CRC_SEED)) crc_i (
    .clk_i, .rst_ni,
    .clear_i(step && (field == F_PRE)), .upd_i(step && (field == F_DATA)),
    .din_i(data_bit), .shift_i(step && (field == F_CRC)), .msb_o(crc_bit)
  );

  always_comb begin
    unique case (field)
      F_PRE:   nxt_bit = pre_last;
      F_DATA:  nxt_bit = data_bit;
      F_CRC:   nxt_bit = crc_bit;
      default: nxt_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mclk_q      <= 1'b0;
      bit_q       <= 1'b0;
      stb_q       <= 1'b0;
      done_pend_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      mclk_q      <= mclk_i;
      stb_q       <= step;
      done_pend_q <= last;
      done_q      <= done_pend_q;
      if (step) bit_q <= nxt_bit;
    end
  end

  assign bit_o     = bit_q;
  assign bit_stb_o = stb_q;
  assign busy_o    = busy;
  assign done_o    = done_q;

  assert_stb_step_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_o |-> $past(busy));

  assert_bit_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_stb_o |-> $stable(bit_o));

  assert_done_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !$past(start_acc)) |-> !busy_o);
endmodule

// File: tb/sector_stream_fmt_tb_top.sv
module sector_stream_fmt_tb_top;
  localparam logic [31:0] POLY = 32'h04C1_1DB7;
  localparam int MAXB = 10240;

  typedef struct packed {
    logic m18;
    int   nsec;
    logic diag;
    int   seed;
    int   bits;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1'b0, 1, 1'b0, 3,  4512},
    '{1'b1, 1, 1'b0, 7,  5008},
    '{1'b0, 2, 1'b0, 11, 9024},
    '{1'b1, 2, 1'b0, 19, 10016},
    '{1'b1, 1, 1'b1, 23, 5008}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, mode18_i = 1'b0, diag_i = 1'b0, mclk_i = 1'b0, bit_en_i = 1'b0;
  logic [7:0]  sec_cnt_i = '0;
  logic [17:0] data_i;
  logic valid_i, ready_o, bit_o, bit_stb_o, busy_o, done_o, underflow_o;

  always #4 clk = ~clk;

  sector_stream_fmt dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i, .sec_cnt_i, .mode18_i, .diag_i, .mclk_i,
    .bit_en_i, .data_i, .valid_i, .ready_o, .bit_o, .bit_stb_o, .busy_o, .done_o,
    .underflow_o
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit wd_hit = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] pat(input int g, input int seed);
    return 18'((g * 181 + seed * 4951) ^ (g << 7));
  endfunction

  // expected stream model
  logic exp_q [MAXB];
  int   exp_len;

  task automatic build(input logic m18, input int nsec, input int seed, input bit uf);
    int p = 0;
    int w_w = m18 ? 18 : 16;
    for (int s = 0; s < nsec; s++) begin
      logic [31:0] crc = '0;
      for (int i = 0; i < 255; i++) exp_q[p++] = 1'b0;
      exp_q[p++] = 1'b1;
      for (int k = 0; k < 256; k++) begin
        int g = s * 256 + k;
        logic [17:0] w = (uf && g == 0) ? 18'h0 : pat(uf ? g - 1 : g, seed);
        if (!m18) w[17:16] = 2'b00;
        for (int b = w_w - 1; b >= 0; b--) begin
          logic fb = crc[31] ^ w[b];
          exp_q[p++] = w[b];
          crc = {crc[30:0], 1'b0} ^ (fb ? POLY : 32'h0);
        end
      end
      for (int j = 31; j >= 0; j--) exp_q[p++] = crc[j];
      for (int i = 0; i < 16 + (m18 ? 96 : 112); i++) exp_q[p++] = 1'b0;
    end
    exp_len = p;
  endtask

  // data source
  int  cur_seed = 0, feed_idx = 0;
  bit  feed_clr = 1'b0, feed_en = 1'b0;
  assign data_i  = pat(feed_idx, cur_seed);
  assign valid_i = feed_en;
  always @(posedge clk) begin
    if (feed_clr) feed_idx <= 0;
    else if (valid_i && ready_o) feed_idx <= feed_idx + 1;
  end

  // stream monitor, samples at negedge
  bit mon_clr = 1'b0;
  int mon_idx = 0, mism = 0, first_bad = -1, done_cnt = 0;
  bit last_seen = 1'b0, busy_at_last = 1'b0, done_on_time = 1'b0;
  always @(negedge clk) begin
    if (mon_clr) begin
      mon_idx = 0; mism = 0; first_bad = -1; done_cnt = 0;
      last_seen = 1'b0; busy_at_last = 1'b0; done_on_time = 1'b0;
    end else begin
      if (last_seen && !done_on_time && done_o && done_cnt == 0) done_on_time = 1'b1;
      if (done_o) done_cnt++;
      last_seen = 1'b0;
      if (bit_stb_o) begin
        if (mon_idx >= exp_len || bit_o !== exp_q[mon_idx]) begin
          mism++;
          if (first_bad < 0) first_bad = mon_idx;
        end
        if (mon_idx == exp_len - 1) begin
          last_seen    = 1'b1;
          busy_at_last = busy_o;
        end
        mon_idx++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !wd_hit) begin
      wd_hit = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // uf: 0 normal, 1 late feed (underflow), 2 valid raised in the word's own step (diag)
  task automatic run(input logic m18, input int nsec, input logic dg, input int seed,
                     input int bits, input int uf, input bit poke, input string nm);
    int t = 0, rises = 0;
    build(m18, nsec, seed, uf == 1);
    check(exp_len == bits, {nm, " R5 model length"}, exp_len, bits);
    cur_seed = seed;
    @(negedge clk); feed_clr = 1'b1; feed_en = 1'b0;
    diag_i = dg; bit_en_i = 1'b1; mclk_i = 1'b0;
    @(posedge clk); #1 mon_clr = 1'b1;
    @(negedge clk); feed_clr = 1'b0;
    @(posedge clk); #1 mon_clr = 1'b0;
    @(negedge clk);
    mode18_i = m18; sec_cnt_i = 8'(nsec); start_i = 1'b1; feed_en = (uf == 0);
    @(negedge clk); start_i = 1'b0;
    if (poke) mode18_i = ~m18;
    if (dg) begin
      repeat (20) @(negedge clk);
      check(mon_idx == 0, {nm, " R11 bit_en ignored in diag"}, mon_idx, 0);
    end
    while (done_cnt == 0 && t < 30000) begin
      if (dg) begin
        if (uf == 2 && rises == 256) feed_en = 1'b1;
        mclk_i = 1'b1;
        @(negedge clk); mclk_i = 1'b0;
        @(negedge clk);
        rises++; t += 2;
      end else begin
        @(negedge clk); t++;
        start_i = 1'b0;
        if (poke && t == 100) begin start_i = 1'b1; sec_cnt_i = 8'd5; end
        if (uf == 1 && mon_idx >= 262) feed_en = 1'b1;
      end
    end
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    check(mism == 0, {nm, " R2 R3 R4 stream, first bad index"}, first_bad, -1);
    check(mon_idx == bits, {nm, " R5 R7 R8 bit count"}, mon_idx, bits);
    check(done_cnt == 1 && done_on_time && !busy_at_last, {nm, " R6 done timing"},
          done_cnt, 1);
    check(underflow_o == (uf == 1), {nm, " R9 R10 underflow flag"}, underflow_o, uf == 1);
    check(!busy_o && !ready_o, {nm, " R9 idle after transfer"}, {busy_o, ready_o}, 0);
    feed_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({ready_o, bit_o, bit_stb_o, busy_o, done_o, underflow_o} == '0,
          "R1 reset state", {ready_o, bit_o, bit_stb_o, busy_o, done_o, underflow_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !ready_o, "R1 idle after reset", {busy_o, ready_o}, 0);

    foreach (VECS[i])
      run(VECS[i].m18, VECS[i].nsec, VECS[i].diag, VECS[i].seed, VECS[i].bits, 0, 1'b0,
          $sformatf("vec%0d", i));

    // R7: zero count start ignored
    @(negedge clk); sec_cnt_i = 8'd0; bit_en_i = 1'b1; diag_i = 1'b0; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (5) @(negedge clk);
    check(!busy_o && !bit_stb_o && !ready_o, "R7 zero count ignored", busy_o, 0);

    // R7 R8: restart and mode change while busy
    run(1'b0, 1, 1'b0, 5, 4512, 0, 1'b1, "poke");
    // R10: word missing at its slot
    run(1'b1, 1, 1'b0, 9, 5008, 1, 1'b0, "underflow");
    // R9: handshake in the same step that needs the word
    run(1'b0, 1, 1'b1, 13, 4512, 2, 1'b0, "bypass");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule